// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM with a 19-bit word address, a 16-bit bidirectional data path, two chip enables of opposite polarity, an output enable, a write enable and two byte-lane strobes. The host raises a request with an address, a write flag, write data and a two-bit byte mask. The controller then plays out one complete read or write cycle on the RAM pins and pulses a one-cycle ready when the access is finished. For a read, the masked read data is presented in that same cycle.

All RAM timing is met by counting clock cycles. Every interval is given as a separate nanosecond parameter, and each is converted to whole clock cycles from the clock period in picoseconds. The conversion rounds up and never yields less than one cycle. Write enable falls and rises only while the address is held still. The controller drives the data bus only after a guard interval has let the RAM release it, and it stops driving one cycle after write enable rises.

The data bus appears as separate in, out and output-enable signals, so a pad ring or a bench can model the tristate. One request is handled at a time.

Top module: `sram_async_ctrl`

## Requirements
- R1: From reset, and whenever no access is in progress, every RAM strobe is inactive: `ram_ce1_n`=1, `ram_ce2`=0, `ram_oe_n`=1, `ram_we_n`=1, `ram_lb_n`=1, `ram_ub_n`=1, `ram_dq_oe`=0, `host_rdy`=0.
- R2: A read request accepted at a clock edge holds both chip enables active, `ram_oe_n`=0 and `ram_we_n`=1 for exactly RD cycles. RD is the largest of the access time, the read cycle time and the output-enable access time, each rounded up to whole clocks (7 at defaults: 70/70/30 ns, 10 ns clock).
- R3: At the edge that ends the read strobes, the RAM data is captured. `host_rdy` is then high for exactly one cycle, with `host_rdata` valid in that cycle.
- R4: Host mask bit 0 selects the lower lane and drives `ram_lb_n` low, covering data bits 7:0. Mask bit 1 selects the upper lane and drives `ram_ub_n` low, covering bits 15:8. In read data, a lane that was not selected returns zeros. A mask of 0 asserts no lane strobe and leaves memory unchanged.
- R5: A write first spends one cycle with address, chip enables and lanes active and `ram_we_n`=1. It then holds `ram_we_n` low for PW cycles (5 at defaults), then high for EW cycles (1 at defaults). `ram_addr` does not change while `ram_we_n` is low.
- R6: During a write, `ram_oe_n` stays 1. `ram_dq_oe` rises only after `ram_we_n` has been low for the guard interval (2 cycles at defaults). It falls one cycle after `ram_we_n` rises. While it is high, `ram_dq_o` carries the host write data.
- R7: After the write strobes end, `host_rdy` pulses for one cycle. The selected lanes of the written word are then what a later read returns.
- R8: After a read, all strobes stay inactive for the chip-enable release interval (3 cycles at defaults) before the next request can be accepted.
- R9: Host request fields changed while an access is in progress have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request; sampled only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| host_rdy | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Captured read data, unselected lanes zero |
| ram_addr | output | 19 | RAM address |
| ram_ce1_n | output | 1 | Chip enable, active low |
| ram_ce2 | output | 1 | Chip enable, active high |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_lb_n | output | 1 | Lower lane strobe, active low |
| ram_ub_n | output | 1 | Upper lane strobe, active low |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | 16 | Data returned from the RAM |

## Verification
A wrong sequencer state or a miscounted interval shows on the strobe pins in the very cycle it occurs. The bench therefore compares every pin on every clock against a cycle schedule it derives from the requirements, and a fault is caught within one clock. The bench's RAM model returns garbage until the access time has elapsed and stores garbage when write data was not driven long enough. An early capture or a shortened data window thus shows up later as wrong read data. A bus-driver enable that is mistimed against the RAM's own drive window is flagged as contention in the cycle it overlaps.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and timing helpers for the asynchronous SRAM controller.
// Assumes all timing parameters are non-negative integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RREC,
        ST_WSET,
        ST_WPUL,
        ST_WEND
    } ctrl_state_t;

    // Round a nanosecond interval up to whole clocks, at least one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned period_ps);
        int unsigned c;
        c = (t_ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Loadable down-counter that times every SRAM interval.
// Assumes load values fit in CNT_W bits; holds at zero until reloaded.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    // Count down, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Cycle sequencer: walks read and write phases and registers the strobes.
// Assumes PW_CYC > WHZ_CYC and all cycle counts >= 1.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 7,
    parameter int HZ_CYC  = 3,
    parameter int PW_CYC  = 5,
    parameter int EW_CYC  = 1,
    parameter int DRV_AT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_zero,
    output logic             ld,
    output logic [CNT_W-1:0] ld_val,
    output logic             accept,
    output logic             capture,
    output logic             acc_on,
    output logic             oe_on,
    output logic             we_on,
    output logic             drv_on,
    output logic             rdy
);

    ctrl_state_t state;

    // Decode accept, capture and timer reloads from the current phase.
    always_comb begin
        accept  = (state == ST_IDLE) && req;
        capture = (state == ST_RD) && cnt_zero;
        ld      = 1'b0;
        ld_val  = '0;
        case (state)
            ST_IDLE: if (req && !req_we) begin
                ld     = 1'b1;
                ld_val = CNT_W'(RD_CYC - 1);
            end
            ST_WSET: begin
                ld     = 1'b1;
                ld_val = CNT_W'(PW_CYC - 1);
            end
            ST_WPUL: if (cnt_zero) begin
                ld     = 1'b1;
                ld_val = CNT_W'(EW_CYC - 1);
            end
            ST_RD: if (cnt_zero) begin
                ld     = 1'b1;
                ld_val = CNT_W'(HZ_CYC - 1);
            end
            default: ;
        endcase
    end

    // Advance the phase and register every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            acc_on <= 1'b0;
            oe_on  <= 1'b0;
            we_on  <= 1'b0;
            drv_on <= 1'b0;
            rdy    <= 1'b0;
        end else begin
            rdy <= 1'b0;
            case (state)
                ST_IDLE: if (req) begin
                    acc_on <= 1'b1;
                    if (req_we) begin
                        state <= ST_WSET;
                    end else begin
                        oe_on <= 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_RD: if (cnt_zero) begin
                    acc_on <= 1'b0;
                    oe_on  <= 1'b0;
                    rdy    <= 1'b1;
                    state  <= ST_RREC;
                end
                ST_RREC: if (cnt_zero) state <= ST_IDLE;
                ST_WSET: begin
                    we_on <= 1'b1;
                    state <= ST_WPUL;
                end
                ST_WPUL: begin
                    if (cnt == CNT_W'(DRV_AT)) drv_on <= 1'b1;
                    if (cnt_zero) begin
                        we_on <= 1'b0;
                        state <= ST_WEND;
                    end
                end
                ST_WEND: begin
                    drv_on <= 1'b0;
                    if (cnt_zero) begin
                        acc_on <= 1'b0;
                        rdy    <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
// Holds the accepted request, forms lane strobes and captures read data.
// Assumes DATA_W is a whole number of bytes; one mask bit per byte lane.
module sram_ctrl_dpath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              acc_on,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_be,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] rdata_q
);

    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] lane_mask;

    // Expand each mask bit over its byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
        assign lane_n[g]           = ~(acc_on & be_q[g]);
    end

    // Latch the request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            be_q    <= in_be;
        end
    end

    // Capture masked read data when the access time expires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= dq_in & lane_mask;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top: converts host single-word requests into timed asynchronous SRAM cycles.
// Assumes one outstanding request; intervals are derived from ns parameters.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 30,
    parameter int T_HZ_NS       = 25,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 35,
    parameter int T_AW_NS       = 50,
    parameter int T_DW_NS       = 30,
    parameter int T_WHZ_NS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_rdy,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce1_n,
    output logic              ram_ce2,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              ram_lb_n,
    output logic              ram_ub_n,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i
);

    localparam int unsigned PER     = CLK_PERIOD_PS;
    localparam int unsigned RD_CYC  = umax(umax(ns_to_cyc(T_AA_NS, PER), ns_to_cyc(T_RC_NS, PER)),
                                           ns_to_cyc(T_OE_NS, PER));
    localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ_NS, PER);
    localparam int unsigned WHZ_CYC = ns_to_cyc(T_WHZ_NS, PER);
    localparam int unsigned DW_CYC  = ns_to_cyc(T_DW_NS, PER);
    localparam int unsigned AW_CYC  = umax(ns_to_cyc(T_AW_NS, PER), 2);
    localparam int unsigned PW_CYC  = umax(umax(ns_to_cyc(T_WP_NS, PER), WHZ_CYC + DW_CYC),
                                           AW_CYC - 1);
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, PER);
    localparam int unsigned EW_CYC  = (WC_CYC > PW_CYC + 1) ? WC_CYC - PW_CYC - 1 : 1;
    localparam int unsigned DRV_AT  = PW_CYC - WHZ_CYC;
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, HZ_CYC), umax(PW_CYC, EW_CYC));
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);
    localparam int          LANES   = DATA_W / 8;

    logic             ld, zero, accept, capture;
    logic [CNT_W-1:0] ld_val, cnt;
    logic             acc_on, oe_on, we_on, drv_on;
    logic [LANES-1:0] lane_n;

    sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .cnt(cnt), .zero(zero)
    );

    sram_ctrl_seq #(
        .CNT_W(CNT_W), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC),
        .PW_CYC(PW_CYC), .EW_CYC(EW_CYC), .DRV_AT(DRV_AT)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .req(host_req), .req_we(host_we),
        .cnt(cnt), .cnt_zero(zero), .ld(ld), .ld_val(ld_val),
        .accept(accept), .capture(capture), .acc_on(acc_on), .oe_on(oe_on),
        .we_on(we_on), .drv_on(drv_on), .rdy(host_rdy)
    );

    sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_dpath (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture), .acc_on(acc_on),
        .in_addr(host_addr), .in_wdata(host_wdata), .in_be(host_be[LANES-1:0]),
        .dq_in(ram_dq_i), .addr_q(ram_addr), .wdata_q(ram_dq_o),
        .lane_n(lane_n), .rdata_q(host_rdata)
    );

    assign ram_ce1_n = ~acc_on;
    assign ram_ce2   = acc_on;
    assign ram_oe_n  = ~oe_on;
    assign ram_we_n  = ~we_on;
    assign ram_dq_oe = drv_on;
    assign ram_lb_n  = lane_n[0];
    assign ram_ub_n  = lane_n[LANES-1];

endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for the SRAM pins, bound to the controller top.
// Assumes default-style timing where the drive guard is at least two cycles.
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_WP_NS       = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_ce1_n,
    input logic              ram_ce2,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              ram_dq_oe,
    input logic              host_rdy
);

    localparam int unsigned WP_CYC = ns_to_cyc(T_WP_NS, CLK_PERIOD_PS);

    logic [15:0] we_lo_cnt;

    // Count consecutive write-enable-low clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_lo_cnt <= '0;
        else if (!ram_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
        else                we_lo_cnt <= '0;
    end

    // R5
    we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> $stable(ram_addr));

    // R5
    we_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_n && we_lo_cnt != 0) |-> (we_lo_cnt >= WP_CYC));

    // R5
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce1_n && ram_ce2));

    // R2
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> ram_we_n);

    // R6
    drv_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (ram_oe_n && !ram_ce1_n));

    // R6
    drv_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> (!ram_we_n && !$past(ram_we_n)));

    // R6
    drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_dq_oe && ram_we_n) |=> !ram_dq_oe);

    // R3
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |=> !host_rdy);

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W(ADDR_W), .CLK_PERIOD_PS(CLK_PERIOD_PS), .T_WP_NS(T_WP_NS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n),
    .ram_ce2(ram_ce2), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_oe(ram_dq_oe), .host_rdy(host_rdy)
);

// File: tb/test_sram_async_ctrl.sv
// Bench: per-cycle schedule comparison plus a behavioural timed RAM model.
module test_sram_async_ctrl;

    // Schedule at 10 ns clock, from the requirements.
    localparam int RD_C  = 7;
    localparam int HZ_C  = 3;
    localparam int PW_C  = 5;
    localparam int WHZ_C = 2;
    localparam int EW_C  = 1;
    localparam int DW_C  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_rdy;
    logic [15:0] host_rdata;
    logic [18:0] ram_addr;
    logic        ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_lb_n, ram_ub_n, ram_dq_oe;
    logic [15:0] ram_dq_o, ram_dq_i;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (.*);

    // ---------------- timed RAM model ----------------
    logic [15:0] ram_mem [int unsigned];
    logic [15:0] exp_mem [int unsigned];
    int          rd_age = 0, hold = 0, dw_age = 0;
    logic [18:0] rd_addr_last = '0;
    logic [15:0] rd_val = '0;
    logic        we_prev = 1'b1;

    function automatic logic [15:0] mem_rd(input logic [18:0] a);
        return ram_mem.exists(a) ? ram_mem[a] : 16'h0000;
    endfunction

    assign ram_dq_i = (rd_age >= RD_C) ? rd_val : 16'hBAD0;

    always @(negedge clk) begin
        logic rd_cond, sel;
        logic [15:0] w, cur;
        sel     = !ram_ce1_n && ram_ce2;
        rd_cond = sel && ram_we_n && !ram_oe_n && !(ram_lb_n && ram_ub_n);
        if (ram_dq_oe) begin
            n_chk++;
            if (rd_cond || hold > 0) begin
                n_fail++;
                $display("FAIL R6 bus contention: act=drive exp=released (hold=%0d)", hold);
            end
        end
        if (rd_cond) begin
            rd_age = (ram_addr == rd_addr_last) ? rd_age + 1 : 1;
            rd_addr_last = ram_addr;
            cur = mem_rd(ram_addr);
            rd_val = {ram_ub_n ? 8'hA5 : cur[15:8], ram_lb_n ? 8'h5A : cur[7:0]};
            hold = HZ_C;
        end else begin
            rd_age = 0;
            if (hold > 0) hold--;
        end
        if (!ram_we_n && ram_dq_oe) dw_age++;
        if (!we_prev && ram_we_n && sel) begin
            w = (dw_age >= DW_C) ? ram_dq_o : 16'hEEEE;
            cur = mem_rd(ram_addr);
            if (!ram_lb_n) cur[7:0]  = w[7:0];
            if (!ram_ub_n) cur[15:8] = w[15:8];
            ram_mem[ram_addr] = cur;
        end
        if (ram_we_n) dw_age = 0;
        we_prev = ram_we_n;
    end

    // ---------------- checks ----------------
    task automatic chk_pins(input string tag, input logic ce, input logic oe, input logic we,
                            input logic drv, input logic rdy, input logic [1:0] lanes,
                            input logic [18:0] a, input logic [15:0] d);
        logic [7:0] act, exp;
        act = {ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n, ram_dq_oe, host_rdy};
        exp = {!ce, ce, !oe, !we, !(ce && lanes[1]), !(ce && lanes[0]), drv, rdy};
        n_chk++;
        if (act !== exp || (ce && ram_addr !== a) || (drv && ram_dq_o !== d)) begin
            n_fail++;
            $display("FAIL %s pins act=%b/%h/%h exp=%b/%h/%h", tag, act, ram_addr, ram_dq_o,
                     exp, a, d);
        end
    endtask

    task automatic chk_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s data act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic start_req(input logic we, input logic [18:0] a, input logic [15:0] d,
                             input logic [1:0] be);
        @(negedge clk);
        chk_pins("R1 idle", 0, 0, 0, 0, 0, 2'b00, '0, '0);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
    endtask

    task automatic end_req(input logic scramble);
        host_req = 1'b0;
        if (scramble) begin // R9: fields change while busy
            host_we = ~host_we; host_addr = ~host_addr; host_wdata = ~host_wdata;
            host_be = ~host_be;
        end
    endtask

    task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be,
                            input logic scramble = 1'b0);
        logic [15:0] cur;
        start_req(1'b1, a, d, be);
        for (int c = 1; c <= 2 + PW_C + EW_C; c++) begin
            @(negedge clk);
            if (c == 1) end_req(scramble);
            if (c == 1)
                chk_pins("R5 R9 setup", 1, 0, 0, 0, 0, be, a, d);
            else if (c <= 1 + PW_C)
                chk_pins("R5 R6 pulse", 1, 0, 1, c >= WHZ_C + 2, 0, be, a, d);
            else if (c <= 1 + PW_C + EW_C)
                chk_pins("R6 release", 1, 0, 0, c == 2 + PW_C, 0, be, a, d);
            else
                chk_pins("R7 done", 0, 0, 0, 0, 1, 2'b00, a, d);
        end
        cur = exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
        if (be[0]) cur[7:0]  = d[7:0];
        if (be[1]) cur[15:8] = d[15:8];
        exp_mem[a] = cur;
    endtask

    task automatic do_read(input logic [18:0] a, input logic [1:0] be,
                           input logic scramble = 1'b0);
        logic [15:0] e;
        e = exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
        e = e & {{8{be[1]}}, {8{be[0]}}};
        start_req(1'b0, a, 16'h0, be);
        for (int c = 1; c <= RD_C + HZ_C; c++) begin
            @(negedge clk);
            if (c == 1) end_req(scramble);
            if (c <= RD_C)
                chk_pins("R2 R9 read", 1, 1, 0, 0, 0, be, a, 16'h0);
            else if (c == RD_C + 1) begin
                chk_pins("R3 rdy", 0, 0, 0, 0, 1, 2'b00, a, 16'h0);
                chk_val("R3 R4 R7 rdata", host_rdata, e);
            end else
                chk_pins("R8 recovery", 0, 0, 0, 0, 0, 2'b00, a, 16'h0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk_pins("R1 reset", 0, 0, 0, 0, 0, 2'b00, '0, '0);
        end
        rst_n = 1'b1;
        // Full-word write/read, including the top address
        do_write(19'h00000, 16'h1234, 2'b11);
        do_read (19'h00000, 2'b11);
        do_write(19'h7FFFF, 16'hBEEF, 2'b11);
        do_read (19'h7FFFF, 2'b11);
        // R4 lane writes and masked reads
        do_write(19'h00000, 16'hAA55, 2'b01);
        do_read (19'h00000, 2'b11);
        do_write(19'h00000, 16'h77CC, 2'b10);
        do_read (19'h00000, 2'b01);
        do_read (19'h00000, 2'b10);
        do_read (19'h00000, 2'b00);
        do_write(19'h00000, 16'hFFFF, 2'b00);
        do_read (19'h00000, 2'b11);
        // R9 fields scrambled mid-access
        do_write(19'h2A5A5, 16'hC3C3, 2'b11, 1'b1);
        do_read (19'h2A5A5, 2'b11, 1'b1);
        // Mixed back-to-back traffic on a small address window
        for (int i = 0; i < 30; i++) begin
            logic [18:0] a;
            a = 19'h40000 + 19'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1)
                do_write(a, 16'($urandom), 2'($urandom_range(0, 3)));
            else
                do_read(a, 2'($urandom_range(0, 3)));
        end
        repeat (4) begin
            @(negedge clk);
            chk_pins("R1 idle tail", 0, 0, 0, 0, 0, 2'b00, '0, '0);
        end
        finish_run();
    end

endmodule